// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Readout Formatter

This block turns a 64-bit two's-complement accumulator value into a 32-bit register result. A request strobe carries the accumulator value, a read kind and three mode bits. One clock later the block presents the formatted word together with a valid flag. Accumulator storage and status-flag updates belong to the surrounding unit.

There are three read kinds. A fractional read shifts the accumulator right and can round the discarded remainder to nearest, with ties going to even. It can then clamp the result to a 16-bit or 32-bit signed range. A signed-integer read clamps the accumulator to signed 32 bits. An unsigned-integer read clamps it to unsigned 32 bits.

In a fractional read, `half_i` selects the 16-bit format. That format keeps accumulator bits 39..24 and always rounds on the 24-bit remainder. Otherwise the 32-bit format keeps bits 39..8, and `round_i` chooses between rounding on the 8-bit remainder and plain truncation. `sat_i` turns range clamping on.

Top module: `mac_acc_readout`

## Requirements
- R1: While `rst_ni` is low, `res_o` and `valid_o` are zero.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `req_i` high. `res_o` changes only in the cycle after a request and holds its value otherwise.
- R3: A fractional read is `kind_i` = 2'b00. With `half_i`=0, `round_i`=0 and `sat_i`=0, the result is accumulator bits 39..8, truncated.
- R4: A fractional read with `half_i`=0 and `round_i`=1 rounds on accumulator bits 7..0. The result goes up by one when the remainder exceeds 0x80. On exactly 0x80 it goes up only when the truncated result is odd.
- R5: A fractional read with `half_i`=1 returns accumulator bits 39..24 in `res_o[15:0]`. It rounds on bits 23..0 with the same rule and a halfway point of 0x800000, whatever the value of `round_i`. `res_o[31:16]` is zero.
- R6: In the 32-bit fractional format with `sat_i`=1, a shifted and rounded value above 0x7FFFFFFF gives 0x7FFFFFFF. A value below -2^31 gives 0x80000000.
- R7: In the 16-bit fractional format with `sat_i`=1, a shifted and rounded value outside the signed 16-bit range gives 0x7FFF when it is positive and 0x8000 when it is negative.
- R8: With `sat_i`=0, a fractional read returns the low 32 bits (32-bit format) or the low 16 bits (16-bit format) of the shifted and rounded value, with no clamping.
- R9: A signed-integer read (`kind_i` = 2'b01) returns the low 32 bits when the accumulator fits in signed 32 bits. Otherwise it returns 0x7FFFFFFF for a non-negative accumulator and 0x80000000 for a negative one.
- R10: An unsigned-integer read (`kind_i` = 2'b10) returns the low 32 bits when accumulator bits 63..32 are all zero. Otherwise it returns 0xFFFFFFFF.
- R11: A request with `kind_i` = 2'b11 returns zero and still raises `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request strobe |
| kind_i | input | 2 | Read kind: 00 fractional, 01 signed, 10 unsigned, 11 reserved |
| acc_i | input | 64 | Accumulator value, two's complement |
| half_i | input | 1 | Fractional 16-bit format select |
| round_i | input | 1 | Round enable for the 32-bit fractional format |
| sat_i | input | 1 | Clamp enable for fractional reads |
| res_o | output | 32 | Formatted result |
| valid_o | output | 1 | Result valid, one cycle after the request |

## Verification
Fractional reads are driven with remainders just below, exactly at and just above the halfway point. Each of these cases is tried with an even and with an odd truncated result, which tells round-to-even apart from round-half-up and from truncation. Accumulators just inside and just outside the signed and unsigned 32-bit limits, and the 16-bit and 32-bit fractional ranges, show whether clamping is applied, which clamp value is chosen from the sign, and that values wrap when clamping is off. One case rounds up across the positive limit, which shows that the range check runs after rounding. Random accumulators with random magnitude, kind and mode bits, sent with gaps between requests, test the valid timing and the holding of the result against a model in the bench.

// File: rtl/mac_rd_pkg.sv
package mac_rd_pkg;
  typedef enum logic [1:0] {
    RD_FRAC = 2'b00,
    RD_SINT = 2'b01,
    RD_UINT = 2'b10,
    RD_RSVD = 2'b11
  } rd_kind_e;
endpackage

// File: rtl/mac_round_sat.sv
// Arithmetic right shift, optional round-half-to-even, optional signed clamp.
module mac_round_sat #(
  parameter int IN_W  = 64,
  parameter int SHIFT = 8,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic             round_en_i,
  input  logic             sat_en_i,
  output logic [OUT_W-1:0] res_o
);
  localparam int SH_W = IN_W - SHIFT + 1;

  logic [SH_W-1:0]     trunc;
  logic [SH_W-1:0]     rnd;
  logic [SHIFT-1:0]    rem;
  logic [SHIFT-1:0]    half;
  logic                inc;
  logic [SH_W-OUT_W:0] top_bits;
  logic                fits;

  always_comb begin
    trunc    = {val_i[IN_W-1], val_i[IN_W-1:SHIFT]};
    rem      = val_i[SHIFT-1:0];
    half     = {1'b1, {(SHIFT-1){1'b0}}};
    inc      = round_en_i && ((rem > half) || ((rem == half) && trunc[0]));
    rnd      = trunc + {{(SH_W-1){1'b0}}, inc};
    top_bits = rnd[SH_W-1:OUT_W-1];
    fits     = (&top_bits) || !(|top_bits);
    if (sat_en_i && !fits)
      res_o = rnd[SH_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    else
      res_o = rnd[OUT_W-1:0];
  end
endmodule

// File: rtl/mac_int_sat.sv
// Integer readout: signed or unsigned clamp to RES_W bits.
module mac_int_sat #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             signed_i,
  output logic [RES_W-1:0] res_o
);
  logic [ACC_W-RES_W:0] s_top;
  logic                 s_fits;
  logic                 u_fits;

  always_comb begin
    s_top  = acc_i[ACC_W-1:RES_W-1];
    s_fits = (&s_top) || !(|s_top);
    u_fits = !(|acc_i[ACC_W-1:RES_W]);
    if (signed_i) begin
      if (s_fits) res_o = acc_i[RES_W-1:0];
      else        res_o = acc_i[ACC_W-1] ? {1'b1, {(RES_W-1){1'b0}}}
                                         : {1'b0, {(RES_W-1){1'b1}}};
    end else begin
      res_o = u_fits ? acc_i[RES_W-1:0] : {RES_W{1'b1}};
    end
  end
endmodule

// File: rtl/mac_acc_readout.sv
module mac_acc_readout
  import mac_rd_pkg::*;
#(
  parameter int ACC_W   = 64,
  parameter int RES_W   = 32,
  parameter int FR_W    = 40,
  parameter int SH_WIDE = 8,
  parameter int SH_HALF = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       kind_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             half_i,
  input  logic             round_i,
  input  logic             sat_i,
  output logic [RES_W-1:0] res_o,
  output logic             valid_o
);
  localparam int HALF_W = RES_W / 2;

  logic [RES_W-1:0]  frac_wide;
  logic [HALF_W-1:0] frac_half;
  logic [RES_W-1:0]  int_res;
  logic [RES_W-1:0]  nxt_res;

  mac_round_sat #(.IN_W(ACC_W), .SHIFT(SH_WIDE), .OUT_W(RES_W)) u_wide (
    .val_i      (acc_i),
    .round_en_i (round_i),
    .sat_en_i   (sat_i),
    .res_o      (frac_wide)
  );

  mac_round_sat #(.IN_W(ACC_W), .SHIFT(SH_HALF), .OUT_W(HALF_W)) u_half (
    .val_i      (acc_i),
    .round_en_i (1'b1),
    .sat_en_i   (sat_i),
    .res_o      (frac_half)
  );

  mac_int_sat #(.ACC_W(ACC_W), .RES_W(RES_W)) u_int (
    .acc_i    (acc_i),
    .signed_i (kind_i == RD_SINT),
    .res_o    (int_res)
  );

  always_comb begin
    unique case (rd_kind_e'(kind_i))
      RD_FRAC:          nxt_res = half_i ? {{(RES_W-HALF_W){1'b0}}, frac_half} : frac_wide;
      RD_SINT, RD_UINT: nxt_res = int_res;
      default:          nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) res_o <= nxt_res;
    end
  end
endmodule

// File: rtl/mac_acc_readout_chk.sv
module mac_acc_readout_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [1:0]  kind_i,
  input logic [63:0] acc_i,
  input logic        half_i,
  input logic [31:0] res_o,
  input logic        valid_o
);
  // R2
  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && $stable(res_o)));
  // R5
  p_half_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'b00 && half_i) |=> (res_o[31:16] == 16'h0));
  // R9
  p_sint_fit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'b01 && ((&acc_i[63:31]) || !(|acc_i[63:31])))
      |=> (res_o == $past(acc_i[31:0])));
  // R10
  p_uint_clip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'b10 && (|acc_i[63:32])) |=> (res_o == 32'hFFFF_FFFF));
  // R11
  p_rsvd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'b11) |=> (res_o == 32'h0 && valid_o));
endmodule

bind mac_acc_readout mac_acc_readout_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .kind_i  (kind_i),
  .acc_i   (acc_i),
  .half_i  (half_i),
  .res_o   (res_o),
  .valid_o (valid_o)
);

// File: tb/mac_acc_readout_test.sv
`timescale 1ns/1ps
module mac_acc_readout_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = 2'b00;
  logic [63:0] acc_i = 64'h0;
  logic        half_i = 1'b0;
  logic        round_i = 1'b0;
  logic        sat_i = 1'b0;
  logic [31:0] res_o;
  logic        valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mac_acc_readout uut (.*);

  function automatic logic [31:0] model(input logic [1:0] k, input logic [63:0] a,
                                        input logic hf, input logic rt, input logic om);
    logic signed [64:0] q;
    logic [63:0] rem, hv;
    longint mx, mn;
    int sh, w;
    bit rnd;
    logic [31:0] m;
    case (k)
      2'b00: begin
        sh  = hf ? 24 : 8;
        w   = hf ? 16 : 32;
        rnd = hf ? 1'b1 : rt;
        q   = $signed({a[63], a}) >>> sh;
        rem = a & ((64'd1 << sh) - 64'd1);
        hv  = 64'd1 << (sh - 1);
        if (rnd && (rem > hv || (rem == hv && q[0]))) q = q + 65'sd1;
        mx = (64'sd1 <<< (w - 1)) - 1;
        mn = -(64'sd1 <<< (w - 1));
        m  = (w == 16) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        if (om && q > mx)      model = 32'(mx) & m;
        else if (om && q < mn) model = 32'(mn) & m;
        else                   model = q[31:0] & m;
      end
      2'b01: begin
        if ($signed(a) >= -64'sd2147483648 && $signed(a) <= 64'sd2147483647) model = a[31:0];
        else model = a[63] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end
      2'b10: model = (a[63:32] == 32'h0) ? a[31:0] : 32'hFFFF_FFFF;
      default: model = 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [1:0] k, input logic [63:0] a,
                    input logic hf, input logic rt, input logic om, input logic [31:0] exp);
    @(negedge clk_i);
    kind_i = k; acc_i = a; half_i = hf; round_i = rt; sat_i = om; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    acc_i = ~a;
    check({tag, " valid R2"}, {31'h0, valid_o}, 32'h1);
    check(tag, res_o, exp);
    check({tag, " model"}, model(k, a, hf, rt, om), exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk_i);
    check("R1 reset res", res_o, 32'h0);
    check("R1 reset valid", {31'h0, valid_o}, 32'h0);
    rst_ni = 1'b1;

    rd("R3 trunc", 2'b00, 64'h0000_00AB_CDEF_1234, 0, 0, 0, 32'hABCD_EF12);
    rd("R3 trunc neg", 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 32'hFFFF_FFFF);
    rd("R4 tie even", 2'b00, 64'h0000_0000_0000_1080, 0, 1, 0, 32'h0000_0010);
    rd("R4 tie odd", 2'b00, 64'h0000_0000_0000_1180, 0, 1, 0, 32'h0000_0012);
    rd("R4 above", 2'b00, 64'h0000_0000_0000_1081, 0, 1, 0, 32'h0000_0011);
    rd("R4 below", 2'b00, 64'h0000_0000_0000_107F, 0, 1, 0, 32'h0000_0010);
    rd("R5 tie even", 2'b00, 64'h0000_0012_3480_0000, 1, 0, 0, 32'h0000_1234);
    rd("R5 tie odd", 2'b00, 64'h0000_0012_3580_0000, 1, 1, 0, 32'h0000_1236);
    rd("R5 above", 2'b00, 64'h0000_0012_3480_0001, 1, 0, 0, 32'h0000_1235);
    rd("R6 pos", 2'b00, 64'h0000_0100_0000_0000, 0, 0, 1, 32'h7FFF_FFFF);
    rd("R6 neg", 2'b00, 64'hFFFF_FF00_0000_0000, 0, 0, 1, 32'h8000_0000);
    rd("R6 round over", 2'b00, 64'h0000_007F_FFFF_FFFF, 0, 1, 1, 32'h7FFF_FFFF);
    rd("R8 wrap32", 2'b00, 64'h0000_0100_0000_0000, 0, 0, 0, 32'h0000_0000);
    rd("R7 pos", 2'b00, 64'h0000_0100_0000_0000, 1, 0, 1, 32'h0000_7FFF);
    rd("R7 neg", 2'b00, 64'hFFFF_FF00_0000_0000, 1, 0, 1, 32'h0000_8000);
    rd("R8 wrap16", 2'b00, 64'h0000_0100_0000_0000, 1, 0, 0, 32'h0000_0000);
    rd("R9 min fit", 2'b01, 64'hFFFF_FFFF_8000_0000, 0, 0, 0, 32'h8000_0000);
    rd("R9 pos clip", 2'b01, 64'h0000_0000_8000_0000, 0, 0, 0, 32'h7FFF_FFFF);
    rd("R9 neg clip", 2'b01, 64'hFFFF_FFFF_7FFF_FFFF, 0, 0, 0, 32'h8000_0000);
    rd("R9 small", 2'b01, 64'h0000_0000_0000_1234, 0, 0, 0, 32'h0000_1234);
    rd("R10 fit", 2'b10, 64'h0000_0000_DEAD_BEEF, 0, 0, 0, 32'hDEAD_BEEF);
    rd("R10 clip", 2'b10, 64'h0000_0001_0000_0000, 0, 0, 0, 32'hFFFF_FFFF);
    rd("R11 rsvd", 2'b11, 64'h1234_5678_9ABC_DEF0, 1, 1, 1, 32'h0000_0000);

    // R2: idle cycles keep the result and drop valid
    rd("R2 pre", 2'b10, 64'h0000_0000_0BAD_F00D, 0, 0, 0, 32'h0BAD_F00D);
    held = res_o;
    acc_i = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (2) begin
      @(negedge clk_i);
      check("R2 idle valid", {31'h0, valid_o}, 32'h0);
      check("R2 idle hold", res_o, held);
    end

    for (int i = 0; i < 400; i++) begin
      logic [1:0]  k;
      logic [63:0] a;
      logic        hf, rt, om;
      string       tg;
      k  = 2'($urandom_range(0, 3));
      a  = {$urandom, $urandom};
      a  = $signed(a) >>> $urandom_range(0, 40);
      hf = 1'($urandom); rt = 1'($urandom); om = 1'($urandom);
      case (k)
        2'b00:   tg = hf ? "R5 R7 R8 rand" : (rt ? "R4 R6 R8 rand" : "R3 R6 R8 rand");
        2'b01:   tg = "R9 rand";
        2'b10:   tg = "R10 rand";
        default: tg = "R11 rand";
      endcase
      @(negedge clk_i);
      kind_i = k; acc_i = a; half_i = hf; round_i = rt; sat_i = om; req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
      check({tg, " valid R2"}, {31'h0, valid_o}, 32'h1);
      check(tg, res_o, model(k, a, hf, rt, om));
      if ($urandom_range(0, 3) == 0) begin
        held = res_o;
        acc_i = ~a;
        @(negedge clk_i);
        check("R2 rand hold", res_o, held);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule